// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register-mapped mailbox that sits between a host bus slave port and the port of an embedded controller. The host loads a command of several words into a bank of sixteen 32-bit word registers, with the opcode in word 0. It then sets the "posted" flag in a control register. The controller sees a pending indication, reads the words over its own port and writes its answer into the same bank: a return value in word 0 and any status words from word 1 upward. It then pulses a respond strobe. The host reads the answer and ends the exchange by writing zero to the control register.

The handshake is a three-state machine. In IDLE, both flags are clear and the bank belongs to the host. In POSTED, the command flag is set and the controller owns the bank. In READY, the response flag is set and the answer waits for the host. The transitions are: IDLE to POSTED on a host control write with bit 0 set (POST). POSTED to READY on the controller respond strobe (RESPOND). READY to IDLE on a host control write with bit 0 clear (RELEASE). Every other event leaves the state unchanged. Host bank writes in POSTED or READY are refused, and they set a sticky error flag.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, every word register, the control register and `ctl_pending` are zero.
- R2: In IDLE, a host write to byte address 4×N (N from 0 to 15) stores the data in word N. The word is then readable at the same host address and at controller index N.
- R3: The control register sits at byte address 0x40, where bit 0 is "posted", bit 1 is "ready" and bit 31 is "error". In IDLE, a host control write with bit 0 = 1 sets posted (POST). `ctl_pending` equals the posted flag.
- R4: While posted is set, a one-cycle `ctl_respond` pulse clears posted and sets ready on the same edge (RESPOND). A respond pulse in IDLE or READY has no effect.
- R5: A host control write with bit 0 = 0 clears ready (RELEASE, READY to IDLE) and clears the error bit. In POSTED it clears only the error bit, and posted stays set.
- R6: While posted or ready is set, a host word write leaves the bank unchanged and sets error bit 31. A host control write with bit 0 = 1 outside IDLE is also ignored and sets bit 31.
- R7: The controller may write any word in any state. If the host and the controller write the same word in the same cycle, the word takes the controller data.
- R8: Host reads at a byte address whose two low bits are nonzero, or at a word index above 16, return zero. Host writes to such addresses change nothing.
- R9: Once set, error bit 31 stays set until a host control write with bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational in host_addr) |
| ctl_addr | input | 4 | Controller word index |
| ctl_wr | input | 1 | Controller word write strobe |
| ctl_wdata | input | 32 | Controller write data |
| ctl_rdata | output | 32 | Controller read data for ctl_addr |
| ctl_respond | input | 1 | One-cycle response strobe |
| ctl_pending | output | 1 | Command posted and not yet answered |

## Verification
Two pairs of functions can fall in the same cycle. A host write and a controller write can target the same word, and a host control write can coincide with the respond strobe. The bench drives both ports in the same cycle on purpose: first on the same word and then on different words, and it also places a clearing write in the cycle of a respond pulse. A behavioural model judges every cycle. In that model the controller data wins, and the state change uses the flags as they stood before the edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POSTED = 2'd1,
        ST_READY  = 2'd2
    } mbx_state_e;

    localparam int POSTED_BIT = 0;
    localparam int READY_BIT  = 1;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          h_we,
    input  logic [IDX_W-1:0]              h_idx,
    input  logic [DATA_W-1:0]             h_wdata,
    input  logic                          c_we,
    input  logic [IDX_W-1:0]              c_idx,
    input  logic [DATA_W-1:0]             c_wdata,
    output logic [WORDS-1:0][DATA_W-1:0]  words
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (c_we && c_idx == IDX_W'(i))
                words[i] <= c_wdata;      // controller has priority
            else if (h_we && h_idx == IDX_W'(i))
                words[i] <= h_wdata;
        end
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post_req,
    input  logic clear_req,
    input  logic word_wr_req,
    input  logic respond,
    output logic posted,
    output logic ready,
    output logic idle,
    output logic err
);
    mbx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (post_req)  state_d = ST_POSTED;
            ST_POSTED: if (respond)   state_d = ST_READY;
            ST_READY:  if (clear_req) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        posted = 1'b0;
        ready  = 1'b0;
        idle   = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle   = 1'b1;
            ST_POSTED: posted = 1'b1;
            ST_READY:  ready  = 1'b1;
            default:   idle   = 1'b1;
        endcase
    end

    // sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (clear_req)
            err <= 1'b0;
        else if (!idle && (word_wr_req || post_req))
            err <= 1'b1;
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int WORDS   = 16,
    parameter int DATA_W  = 32,
    parameter int HOST_AW = 8,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic [IDX_W-1:0]   ctl_addr,
    input  logic               ctl_wr,
    input  logic [DATA_W-1:0]  ctl_wdata,
    output logic [DATA_W-1:0]  ctl_rdata,
    input  logic               ctl_respond,
    output logic               ctl_pending
);
    localparam int SEL_W = HOST_AW - 2;

    logic [SEL_W-1:0]              word_sel;
    logic                          aligned, hit_word, hit_csr;
    logic                          post_req, clear_req, word_wr_req;
    logic                          posted, ready, idle, err;
    logic [WORDS-1:0][DATA_W-1:0]  bank_q;
    logic [DATA_W-1:0]             csr_val;

    // host address decode
    assign word_sel    = host_addr[HOST_AW-1:2];
    assign aligned     = (host_addr[1:0] == 2'b00);
    assign hit_word    = aligned && (word_sel < SEL_W'(WORDS));
    assign hit_csr     = aligned && (word_sel == SEL_W'(WORDS));
    assign post_req    = host_wr && hit_csr && host_wdata[0];
    assign clear_req   = host_wr && hit_csr && !host_wdata[0];
    assign word_wr_req = host_wr && hit_word;

    mbx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_req    (post_req),
        .clear_req   (clear_req),
        .word_wr_req (word_wr_req),
        .respond     (ctl_respond),
        .posted      (posted),
        .ready       (ready),
        .idle        (idle),
        .err         (err)
    );

    mbx_bank #(.WORDS(WORDS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (word_wr_req && idle),
        .h_idx   (word_sel[IDX_W-1:0]),
        .h_wdata (host_wdata),
        .c_we    (ctl_wr),
        .c_idx   (ctl_addr),
        .c_wdata (ctl_wdata),
        .words   (bank_q)
    );

    always_comb begin
        csr_val             = '0;
        csr_val[POSTED_BIT] = posted;
        csr_val[READY_BIT]  = ready;
        csr_val[DATA_W-1]   = err;
    end

    always_comb begin
        host_rdata = '0;
        if (hit_word)
            host_rdata = bank_q[word_sel[IDX_W-1:0]];
        else if (hit_csr)
            host_rdata = csr_val;
    end

    assign ctl_rdata   = bank_q[ctl_addr];
    assign ctl_pending = posted;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [IDX_W-1:0]              ctl_addr,
    input logic                          ctl_wr,
    input logic [DATA_W-1:0]             ctl_wdata,
    input logic                          ctl_respond,
    input logic                          ctl_pending,
    input logic                          posted,
    input logic                          ready,
    input logic                          err,
    input logic                          post_req,
    input logic                          clear_req,
    input logic                          word_wr_req,
    input logic [WORDS-1:0][DATA_W-1:0]  bank_q
);
    a_r3_pending_from_post: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_pending) |-> $past(post_req));

    a_r4_respond_swaps: assert property (@(posedge clk) disable iff (!rst_n)
        (posted && ctl_respond) |=> (ready && !posted));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({posted, ready}));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clear_req) |=> (!ready && !posted && !err));

    a_r6_err_on_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((posted || ready) && word_wr_req) |=> err);

    a_r6_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ((posted || ready) && !ctl_wr) |=> $stable(bank_q));

    a_r7_ctl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (bank_q[$past(ctl_addr)] == $past(ctl_wdata)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear_req) |=> err);
endmodule

bind cmd_mailbox mbx_checker #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/100ps
module sim_cmd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [3:0]  ctl_addr = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        ctl_respond = 1'b0;
    logic        ctl_pending;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    logic [31:0] mem [16];
    bit          m_post, m_ready, m_err;

    cmd_mailbox u0 (.*);

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_read(logic [7:0] a);
        int idx;
        idx = int'(a >> 2);
        if (a[1:0] != 2'b00) return 32'h0;
        if (idx < 16) return mem[idx];
        if (idx == 16) return {m_err, 29'h0, m_ready, m_post};
        return 32'h0;
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: update the model from the inputs seen at the edge, then compare
    task automatic cycle();
        int  hidx;
        bit  al, idle, n_post, n_ready, n_err;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] = 32'h0;
            m_post = 0; m_ready = 0; m_err = 0;
        end else begin
            hidx = int'(host_addr >> 2);
            al   = (host_addr[1:0] == 2'b00);
            idle = !m_post && !m_ready;
            n_post = m_post; n_ready = m_ready; n_err = m_err;
            if (host_wr && al && hidx < 16) begin
                if (idle && !(ctl_wr && int'(ctl_addr) == hidx)) mem[hidx] = host_wdata;
                if (!idle) n_err = 1;
            end
            if (host_wr && al && hidx == 16) begin
                if (host_wdata[0]) begin
                    if (idle) n_post = 1; else n_err = 1;
                end else begin
                    n_err = 0;
                    if (m_ready) n_ready = 0;
                end
            end
            if (m_post && ctl_respond) begin
                n_post = 0; n_ready = 1;
            end
            if (ctl_wr) mem[ctl_addr] = ctl_wdata;
            m_post = n_post; m_ready = n_ready; m_err = n_err;
        end
        #1;
        check("ctl_pending", {31'h0, ctl_pending}, {31'h0, m_post});
        check("ctl_rdata", ctl_rdata, mem[ctl_addr]);
        check("host_rdata", host_rdata, model_read(host_addr));
    endtask

    task automatic host_write(logic [7:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        cycle();
        host_wr = 1'b0;
    endtask

    task automatic ctl_write(logic [3:0] a, logic [31:0] d);
        ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1;
        cycle();
        ctl_wr = 1'b0;
    endtask

    task automatic host_look(logic [7:0] a);
        host_addr = a;
        cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        cycle(); cycle();
        rst_n = 1'b1;
        host_look(8'h40);
        check("R1 control zero", host_rdata, 32'h0);
        host_look(8'h14);
        ctl_addr = 4'd9;
        cycle();

        // R2: host loads a command in IDLE
        tag = "R2";
        host_write(8'h00, 32'h00A5_1234);
        host_write(8'h04, 32'h0011_2233);
        host_write(8'h08, 32'h00FF_EE01);
        host_write(8'h3C, 32'hDEAD_BEEF);
        host_look(8'h3C);
        check("R2 word15", host_rdata, 32'hDEAD_BEEF);
        for (int i = 0; i < 4; i++) begin
            ctl_addr = 4'(i);
            cycle();
        end

        // R8: unaligned and unimplemented addresses
        tag = "R8";
        host_write(8'h05, 32'h1111_1111);
        host_write(8'h50, 32'h2222_2222);
        host_write(8'h41, 32'h0000_0001);
        host_look(8'h41);
        check("R8 unaligned read", host_rdata, 32'h0);
        host_look(8'h44);
        check("R8 index17 read", host_rdata, 32'h0);
        host_look(8'h04);
        check("R8 word1 untouched", host_rdata, 32'h0011_2233);

        // R3: post the command
        tag = "R3";
        host_write(8'h40, 32'h0000_0001);
        host_look(8'h40);
        check("R3 pending", {31'h0, ctl_pending}, 32'h1);

        // R6: locked bank write sets error
        tag = "R6";
        host_write(8'h04, 32'hBAD0_0000);
        host_look(8'h04);
        check("R6 word1 kept", host_rdata, 32'h0011_2233);
        host_look(8'h40);
        check("R6 err set", host_rdata, 32'h8000_0001);

        // R9: error stays, then a zero write clears it but keeps posted
        tag = "R9";
        cycle(); cycle();
        check("R9 err sticky", host_rdata, 32'h8000_0001);
        host_write(8'h40, 32'h0);
        check("R9 cleared, posted kept", host_rdata, 32'h0000_0001);

        // R7: controller writes the answer while posted
        tag = "R7";
        ctl_write(4'd0, 32'h0000_0000);
        ctl_write(4'd1, 32'h0012_3456);
        ctl_write(4'd2, 32'h0065_4321);

        // R4: respond, then a second respond is ignored
        tag = "R4";
        ctl_respond = 1'b1;
        host_addr   = 8'h40;
        cycle();
        ctl_respond = 1'b0;
        check("R4 ready", host_rdata, 32'h0000_0002);
        ctl_respond = 1'b1;
        cycle();
        ctl_respond = 1'b0;
        check("R4 respond in ready ignored", host_rdata, 32'h0000_0002);
        host_look(8'h04);
        check("R4 status word", host_rdata, 32'h0012_3456);

        // R6: posting while ready is refused
        tag = "R6";
        host_write(8'h40, 32'h0000_0001);
        host_look(8'h40);
        check("R6 post in ready", host_rdata, 32'h8000_0002);

        // R5: release
        tag = "R5";
        host_write(8'h40, 32'h0);
        check("R5 idle", host_rdata, 32'h0);

        // R4: respond in IDLE is ignored
        tag = "R4";
        ctl_respond = 1'b1;
        cycle();
        ctl_respond = 1'b0;
        check("R4 respond in idle", host_rdata, 32'h0);

        // R7: same-word collision, then different words
        tag = "R7";
        ctl_addr = 4'd3; ctl_wdata = 32'hC0C0_C0C0; ctl_wr = 1'b1;
        host_write(8'h0C, 32'h4545_4545);
        ctl_wr = 1'b0;
        host_look(8'h0C);
        check("R7 ctl wins", host_rdata, 32'hC0C0_C0C0);
        ctl_addr = 4'd6; ctl_wdata = 32'h0000_0066; ctl_wr = 1'b1;
        host_write(8'h1C, 32'h0000_0077);
        ctl_wr = 1'b0;
        host_look(8'h1C);
        check("R7 host word7", host_rdata, 32'h0000_0077);
        host_look(8'h18);
        check("R7 ctl word6", host_rdata, 32'h0000_0066);

        // R5: clear write coinciding with respond while posted
        tag = "R5";
        host_write(8'h40, 32'h0000_0001);
        ctl_respond = 1'b1;
        host_write(8'h40, 32'h0);
        ctl_respond = 1'b0;
        check("R5 clear+respond in posted", host_rdata, 32'h0000_0002);
        host_write(8'h40, 32'h0);
        check("R5 final idle", host_rdata, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule